// File: doc/BRIEF.md
# Compact Instruction Stream Expander

The expander sits between an instruction fetch path and a decoder that only understands the full 128-bit instruction format. Its input is a stream of 64-bit words. Each instruction in that stream is either a full instruction that spans two words, low half first, or a packed instruction that fits in one word. A single marker bit in the first word tells the two forms apart. Full instructions pass through bit for bit. A packed instruction holds small indices into four 32-entry dictionaries: control, data type, sub-register and source operand. The expander looks up those dictionaries and scatters the entries back into their native field positions. It also copies the fields that are stored directly.

Two dictionary sets exist, one for an older generation and one for a newer one, and a generation input chooses between them. The generation also decides where the flag bits land. Both sides of the block use a valid/ready handshake. Exactly one 128-bit instruction leaves the block for each instruction that enters it.

Top module: `cxp_expander`

## Requirements
- R1: In the cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: When bit 29 of an instruction's first word is 1, that word is a packed instruction. It is accepted alone, and its expansion appears on `out_insn` with `out_valid` set one clock edge after acceptance.
- R3: When bit 29 of an instruction's first word is 0, the instruction is full. `out_valid` stays low after the first word. After the second word is accepted, `out_insn` equals {second word, first word} unchanged. Bit 29 of the second word is never interpreted.
- R4: Packed word fields (word bit positions) are: opcode[6:0], debug[7], control index[12:8], data-type index[17:13], sub-register index[22:18], accumulator write[23], conditional modifier[27:24], flag sub-register[28], marker[29], source-0 index low[31:30], source-0 index high[34:32], source-1 index[39:35], destination register[47:40], source-0 register[55:48], source-1 register[63:56].
- R5: In the expansion, control entry bits 15:0 go to native bits 23:8 and control entry bit 16 goes to native bit 31. Control entries are 17 bits for generation 0 and 19 bits for generation 1.
- R6: When `gen_sel` is 1, control entry bits 18:17 go to native bits 90:89. When `gen_sel` is 0, the flag sub-register bit goes to native bit 89 and bit 90 is 0.
- R7: The 18-bit data-type entry fills native bits 46:32 with its bits 14:0 and native bits 63:61 with its bits 17:15.
- R8: The 15-bit sub-register entry holds three 5-bit numbers, from the low end: destination, source 0, source 1. They land at native bits 52:48, 68:64 and 100:96.
- R9: Each 12-bit source-index entry lands at native bits 88:77 for source 0 and at native bits 120:109 for source 1. The source-0 dictionary index is {high 3 bits, low 2 bits}.
- R10: Direct copies into the native word are: opcode to bits 6:0, debug to 30, accumulator write to 28, conditional modifier to 27:24, destination register to 60:53, source-0 register to 76:69, and source-1 register to 108:101. Every other native bit, bit 29 included, is 0.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_insn` holds its value and `in_ready` is 0. In all other cases `in_ready` is 1.
- R12: Each dictionary entry is ((index × M) XOR X) truncated to the entry width. The (M, X) pairs in hex are as follows. Generation 0: control (12345, 101), data type (26B3D, 8421), sub-register (4A53, 0), source (B5D, 0). Generation 1: control (31E27, 40002), data type (1D5A9, 20001), sub-register (3C4B, 421), source (693, 10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_sel | input | 1 | Dictionary set and flag placement (0 older, 1 newer), sampled when a packed word is accepted |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted on this edge when valid |
| in_data | input | 64 | Input instruction word |
| out_valid | output | 1 | Native instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | 128 | Native 128-bit instruction |

## Verification
The bench drives random packed words with random field values under both generations. A wrong table, a wrong bit position or a swapped source-0 index split then shows up as a native mismatch. Directed packed words with all indices at 0 and at 31 probe the ends of each dictionary and the flag placement that depends on the generation. Full instructions are sent with random halves, including a second word whose bit 29 is set, which shows whether the pass-through path ever reinterprets the second word. Every output is held stalled for two cycles to confirm that the output value and the back-pressure on the input both stay put.

// File: rtl/cxp_pkg.sv
package cxp_pkg;

    localparam int WORD_W   = 64;
    localparam int NAT_W    = 2 * WORD_W;
    localparam int IDX_W    = 5;
    localparam int TBL_N    = 1 << IDX_W;
    localparam int N_GEN    = 2;
    localparam int CTRL_W   = 19;
    localparam int CTRL_W0  = 17;
    localparam int DT_W     = 18;
    localparam int SR_W     = 15;
    localparam int SRC_W    = 12;
    localparam int MARK_BIT = 29;

    typedef enum logic [1:0] {
        TBL_CTRL   = 2'd0,
        TBL_DTYPE  = 2'd1,
        TBL_SUBREG = 2'd2,
        TBL_SRC    = 2'd3
    } tbl_kind_e;

    // Packed word layout, most significant field first
    typedef struct packed {
        logic [7:0]       src1_reg;
        logic [7:0]       src0_reg;
        logic [7:0]       dst_reg;
        logic [IDX_W-1:0] src1_idx;
        logic [2:0]       src0_idx_hi;
        logic [1:0]       src0_idx_lo;
        logic             marker;
        logic             flag_sub;
        logic [3:0]       cond_mod;
        logic             acc_wr;
        logic [IDX_W-1:0] sub_idx;
        logic [IDX_W-1:0] dt_idx;
        logic [IDX_W-1:0] ctl_idx;
        logic             debug;
        logic [6:0]       opcode;
    } packed_word_t;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DT_W-1:0]   dtype;
        logic [SR_W-1:0]   subreg;
        logic [SRC_W-1:0]  src0;
        logic [SRC_W-1:0]  src1;
    } lookup_t;

    // Dictionary contents: ((idx * mul) ^ xr) truncated to the entry width
    function automatic logic [31:0] tbl_entry(tbl_kind_e k, logic gen, logic [IDX_W-1:0] idx);
        logic [31:0] mul, xr, msk, prod;
        unique case (k)
            TBL_CTRL: begin
                mul = gen ? 32'h0003_1E27 : 32'h0001_2345;
                xr  = gen ? 32'h0004_0002 : 32'h0000_0101;
                msk = gen ? ((32'd1 << CTRL_W) - 1) : ((32'd1 << CTRL_W0) - 1);
            end
            TBL_DTYPE: begin
                mul = gen ? 32'h0001_D5A9 : 32'h0002_6B3D;
                xr  = gen ? 32'h0002_0001 : 32'h0000_8421;
                msk = (32'd1 << DT_W) - 1;
            end
            TBL_SUBREG: begin
                mul = gen ? 32'h0000_3C4B : 32'h0000_4A53;
                xr  = gen ? 32'h0000_0421 : 32'h0000_0000;
                msk = (32'd1 << SR_W) - 1;
            end
            default: begin
                mul = gen ? 32'h0000_0693 : 32'h0000_0B5D;
                xr  = gen ? 32'h0000_0010 : 32'h0000_0000;
                msk = (32'd1 << SRC_W) - 1;
            end
        endcase
        prod = {{(32-IDX_W){1'b0}}, idx} * mul;
        return (prod ^ xr) & msk;
    endfunction

endpackage

// File: rtl/cxp_tables.sv
module cxp_tables
    import cxp_pkg::*;
(
    input  logic             gen,
    input  packed_word_t     pw,
    output lookup_t          lk
);
    logic [CTRL_W-1:0] ctrl_rom [N_GEN][TBL_N];
    logic [DT_W-1:0]   dt_rom   [N_GEN][TBL_N];
    logic [SR_W-1:0]   sr_rom   [N_GEN][TBL_N];
    logic [SRC_W-1:0]  src_rom  [N_GEN][TBL_N];

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        for (genvar i = 0; i < TBL_N; i++) begin : g_ent
            assign ctrl_rom[g][i] = CTRL_W'(tbl_entry(TBL_CTRL,   1'(g), IDX_W'(i)));
            assign dt_rom[g][i]   = DT_W'(tbl_entry(TBL_DTYPE,    1'(g), IDX_W'(i)));
            assign sr_rom[g][i]   = SR_W'(tbl_entry(TBL_SUBREG,   1'(g), IDX_W'(i)));
            assign src_rom[g][i]  = SRC_W'(tbl_entry(TBL_SRC,     1'(g), IDX_W'(i)));
        end
    end

    logic [IDX_W-1:0] src0_full;
    assign src0_full = {pw.src0_idx_hi, pw.src0_idx_lo};

    always_comb begin
        lk.ctrl   = ctrl_rom[gen][pw.ctl_idx];
        lk.dtype  = dt_rom[gen][pw.dt_idx];
        lk.subreg = sr_rom[gen][pw.sub_idx];
        lk.src0   = src_rom[gen][src0_full];
        lk.src1   = src_rom[gen][pw.src1_idx];
    end
endmodule

// File: rtl/cxp_expand.sv
module cxp_expand
    import cxp_pkg::*;
(
    input  logic             gen,
    input  packed_word_t     pw,
    input  lookup_t          lk,
    output logic [NAT_W-1:0] native
);
    logic [31:0] dw0, dw1, dw2, dw3;

    always_comb begin
        dw0 = '0;
        dw1 = '0;
        dw2 = '0;
        dw3 = '0;
        // header dword
        dw0[6:0]   = pw.opcode;
        dw0[23:8]  = lk.ctrl[15:0];
        dw0[27:24] = pw.cond_mod;
        dw0[28]    = pw.acc_wr;
        dw0[30]    = pw.debug;
        dw0[31]    = lk.ctrl[16];
        // destination dword
        dw1[14:0]  = lk.dtype[14:0];
        dw1[20:16] = lk.subreg[4:0];
        dw1[28:21] = pw.dst_reg;
        dw1[31:29] = lk.dtype[17:15];
        // source 0 dword, flag placement depends on generation
        dw2[4:0]   = lk.subreg[9:5];
        dw2[12:5]  = pw.src0_reg;
        dw2[24:13] = lk.src0;
        if (gen) dw2[26:25] = lk.ctrl[18:17];
        else     dw2[25]    = pw.flag_sub;
        // source 1 dword
        dw3[4:0]   = lk.subreg[14:10];
        dw3[12:5]  = pw.src1_reg;
        dw3[24:13] = lk.src1;
        native = {dw3, dw2, dw1, dw0};
    end
endmodule

// File: rtl/cxp_stream.sv
module cxp_stream
    import cxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic [NAT_W-1:0]  expanded,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NAT_W-1:0]  out_insn,
    output logic              half
);
    logic [WORD_W-1:0] hold;
    logic              fire;

    assign in_ready = !out_valid || out_ready;
    assign fire     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_insn  <= '0;
            hold      <= '0;
            half      <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (fire) begin
                if (half) begin
                    out_insn  <= {in_data, hold};
                    out_valid <= 1'b1;
                    half      <= 1'b0;
                end else if (in_data[MARK_BIT]) begin
                    out_insn  <= expanded;
                    out_valid <= 1'b1;
                end else begin
                    hold <= in_data;
                    half <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cxp_expander.sv
module cxp_expander
    import cxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NAT_W-1:0]  out_insn
);
    packed_word_t     pw;
    lookup_t          lk;
    logic [NAT_W-1:0] expanded;
    logic             mid_native;

    assign pw = packed_word_t'(in_data);

    cxp_tables u_tables (
        .gen (gen_sel),
        .pw  (pw),
        .lk  (lk)
    );

    cxp_expand u_expand (
        .gen    (gen_sel),
        .pw     (pw),
        .lk     (lk),
        .native (expanded)
    );

    cxp_stream u_stream (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .expanded  (expanded),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_insn  (out_insn),
        .half      (mid_native)
    );
endmodule

// File: rtl/cxp_expander_chk.sv
module cxp_expander_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic [63:0]  in_data,
    input logic         out_valid,
    input logic         out_ready,
    input logic [127:0] out_insn,
    input logic         half
);
    logic fire;
    assign fire = in_valid && in_ready;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !out_valid && !half);

    p_packed_one_word_r2: assert property (@(posedge clk) disable iff (rst)
        fire && !half && in_data[29] |=> out_valid);

    p_native_first_r3: assert property (@(posedge clk) disable iff (rst)
        fire && !half && !in_data[29] |=> !out_valid && half);

    p_native_second_r3: assert property (@(posedge clk) disable iff (rst)
        fire && half |=> out_valid && !half);

    p_marker_zero_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_insn[29]);

    p_hold_output_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_insn));

    p_stall_input_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);
endmodule

bind cxp_expander cxp_expander_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_insn  (out_insn),
    .half      (mid_native)
);

// File: tb/tb_cxp_expander.sv
module tb_cxp_expander;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         gen_sel = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [63:0]  in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_insn;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    cxp_expander dut (
        .clk(clk), .rst(rst), .gen_sel(gen_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn)
    );

    // R12 dictionary model
    function automatic logic [31:0] dict(int k, bit g, logic [4:0] i);
        logic [31:0] m, x;
        int w;
        case (k)
            0: begin m = g ? 32'h31E27 : 32'h12345; x = g ? 32'h40002 : 32'h101; w = g ? 19 : 17; end
            1: begin m = g ? 32'h1D5A9 : 32'h26B3D; x = g ? 32'h20001 : 32'h8421; w = 18; end
            2: begin m = g ? 32'h3C4B  : 32'h4A53;  x = g ? 32'h421   : 32'h0;    w = 15; end
            default: begin m = g ? 32'h693 : 32'hB5D; x = g ? 32'h10 : 32'h0; w = 12; end
        endcase
        return ((32'(i) * m) ^ x) & ((32'd1 << w) - 1);
    endfunction

    // R4..R10 reference expansion
    function automatic logic [127:0] ref_expand(logic [63:0] w, bit g);
        logic [127:0] n;
        logic [31:0]  c, d, s;
        n = '0;
        c = dict(0, g, w[12:8]);
        d = dict(1, g, w[17:13]);
        s = dict(2, g, w[22:18]);
        n[6:0]     = w[6:0];
        n[30]      = w[7];
        n[28]      = w[23];
        n[27:24]   = w[27:24];
        n[23:8]    = c[15:0];
        n[31]      = c[16];
        n[46:32]   = d[14:0];
        n[63:61]   = d[17:15];
        n[52:48]   = s[4:0];
        n[68:64]   = s[9:5];
        n[100:96]  = s[14:10];
        n[60:53]   = w[47:40];
        n[76:69]   = w[55:48];
        n[108:101] = w[63:56];
        n[88:77]   = dict(3, g, {w[34:32], w[31:30]}) & 32'hFFF;
        n[120:109] = dict(3, g, w[39:35]) & 32'hFFF;
        if (g) n[90:89] = c[18:17];
        else   n[89]    = w[28];
        return n;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(logic [63:0] w, bit g);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        gen_sel  = g;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // R11: stall two cycles, then drain
    task automatic pop(logic [127:0] exp, string tag);
        @(negedge clk);
        chk({tag, " valid"}, 128'(out_valid), 128'd1);
        chk(tag, out_insn, exp);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk("R11 hold", out_insn, exp);
            chk("R11 stall ready", 128'(in_ready), 128'd0);
        end
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
        @(negedge clk);
        chk("R11 drained", 128'({out_valid, in_ready}), 128'b01);
    endtask

    task automatic run_packed(logic [63:0] w, bit g, string tag);
        w[29] = 1'b1;
        push(w, g);
        pop(ref_expand(w, g), tag);
    endtask

    task automatic run_native(logic [63:0] lo, logic [63:0] hi);
        lo[29] = 1'b0;
        push(lo, 1'b0);
        @(negedge clk);
        chk("R3 no output after first word", 128'(out_valid), 128'd0);
        push(hi, 1'b1);
        pop({hi, lo}, "R3 native pass-through");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 reset state", 128'({out_valid, in_ready}), 128'b01);

        // directed corners: all-zero and all-ones indices, both generations (R5 R6 R9 R12)
        run_packed(64'h0, 1'b0, "R2 zero word gen0");
        run_packed(64'h0, 1'b1, "R6 zero word gen1");
        run_packed(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R5 ones gen0");
        run_packed(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R6 ones gen1");
        // source-0 split: low part only, then high part only (R9)
        run_packed(64'h0000_0000_C000_0000, 1'b0, "R9 split low");
        run_packed(64'h0000_0007_0000_0000, 1'b1, "R9 split high");
        // copies and flag sub-register (R4 R7 R8 R10)
        run_packed(64'hA55A_3C00_1F80_107F, 1'b0, "R10 copies gen0");
        run_packed(64'hA55A_3C00_1F80_107F, 1'b1, "R8 copies gen1");
        // native with marker set in second word (R3)
        run_native(64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF);
        run_native(64'h0, 64'h0);

        for (int n = 0; n < 300; n++) begin
            logic [63:0] w;
            w = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) run_native(w, {$urandom, $urandom});
            else run_packed(w, 1'($urandom_range(0, 1)), "R7 random packed");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule